// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block sits between the comparators that watch a three-level PWM pin and the two gate drivers of a synchronous buck power stage. Every clock it turns the comparator code into a command (high, low or mid-band), filters out short trips through the mid band, and steps a small phase machine. The machine enables the high-side gate for a high command and the low-side gate for a low command. It never lets both be on together. A gate is enabled only after both gate-low feedback flags confirm that the stage has discharged and a minimum off interval has passed.

A skip-mode select switches the low side to diode emulation. In that mode the low side still turns on after the dead time, but it drops as soon as the inductor current reaches zero and stays off until the next falling PWM command. The active-low disable and the supply-good flag each override everything and park the stage with both gates off. A separate comparator with hysteresis on an unsigned die-temperature code drives an active-low over-temperature flag. The flag only reports and has no effect on the gates. All delays are parameters counted in clock cycles.

Top module: `buck_gate_seq`

## Requirements
- R1: The comparator pair maps to a command as follows: above=1,below=0 is high; above=0,below=1 is low; 00 is mid-band; the illegal code 11 is also treated as mid-band.
- R2: While `dis_n` is 0, both `hs_en` and `ls_en` are 0 from the next clock on, whatever the PWM code or the mode.
- R3: While `supply_ok` is 0, both gate enables are 0 from the next clock on. After `supply_ok` or `dis_n` returns high, a gate turns on again only through the dead-time check of R5.
- R4: `hs_en` and `ls_en` are never 1 in the same cycle, and each enable rises only after a cycle in which the other one was 0.
- R5: A gate enable rises only on a clock edge where both `hs_fb_low` and `ls_fb_low` are 1. The phase with both gates off must also have lasted at least DT_TO_HS cycles (before the high side) or DT_TO_LS cycles (before the low side), default 2 each. Slow feedback therefore stretches the dead time.
- R6: With `skip_n`=1, a high command gives high side on and low side off, and a low command gives low side on and high side off. The outputs react two clocks after the comparator code changes: one clock in the filter and one in the phase register.
- R7: A mid-band code must be seen on HOLDOFF consecutive clocks (default 17) before both gates are switched off. Shorter excursions, of HOLDOFF-1 cycles or less, leave the gates as they were.
- R8: With `skip_n`=0, the high side follows the command unchanged. The low side turns on after the dead time, turns off on the clock after `zero_cur` is seen high, and stays off until the command leaves the low level and returns.
- R9: With `skip_n`=1, `zero_cur` has no effect: the low side stays on for as long as the command is low.
- R10: `hot_n` goes 0 on the clock after `temp_code` (1 LSB = 1 degree) is at least 150. It returns to 1 only on the clock after `temp_code` is at most 135, and holds its value in between. It never alters the gate enables.
- R11: After a synchronous reset both gate enables are 0, `hot_n` is 1, and the command starts as mid-band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_above | input | 1 | Comparator: PWM pin above the high threshold |
| pwm_below | input | 1 | Comparator: PWM pin below the low threshold |
| dis_n | input | 1 | Disable, active low |
| skip_n | input | 1 | Skip-mode select, active low (diode emulation) |
| supply_ok | input | 1 | Control supply above its lockout threshold |
| hs_fb_low | input | 1 | High-side gate has fallen below its turn-off level |
| ls_fb_low | input | 1 | Low-side gate has fallen below its turn-off level |
| zero_cur | input | 1 | Inductor current has reached zero |
| temp_code | input | TEMP_W | Unsigned die temperature, 1 LSB per degree |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| hot_n | output | 1 | Over-temperature flag, active low |

## Verification
The dead-time assertions assume that the gate feedback flags behave like a real stage. Each flag drops to 0 while its own gate is enabled and comes back to 1 some cycles after the enable falls, and it never reports a gate as low before the block has switched it off. The bench keeps to this with a small plant model that derives both flags from the observed enables, using a programmable fall delay, so longer delays stretch the dead time. All comparator codes, mode pins and temperature codes change only at the falling clock edge, so each rising edge samples a settled value.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

    typedef enum logic [1:0] {
        CMD_MID  = 2'd0,
        CMD_HIGH = 2'd1,
        CMD_LOW  = 2'd2
    } pwm_cmd_t;

    typedef enum logic [1:0] {
        PH_OFF = 2'd0,
        PH_HS  = 2'd1,
        PH_LS  = 2'd2,
        PH_ZC  = 2'd3
    } phase_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

    // Comparator pair to command; the illegal code folds into mid-band (R1)
    function automatic pwm_cmd_t decode_pwm(input logic above, input logic below);
        unique case ({above, below})
            2'b10:   return CMD_HIGH;
            2'b01:   return CMD_LOW;
            default: return CMD_MID;
        endcase
    endfunction

    function automatic gate_pair_t phase_gates(input phase_t p);
        gate_pair_t g;
        g.hs = (p == PH_HS);
        g.ls = (p == PH_LS);
        return g;
    endfunction

endpackage

// File: rtl/bgs_pwm_filter.sv
module bgs_pwm_filter
    import bgs_pkg::*;
#(
    parameter int HOLDOFF = 17
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pwm_above,
    input  logic     pwm_below,
    output pwm_cmd_t cmd
);
    localparam int HW = (HOLDOFF > 1) ? $clog2(HOLDOFF) : 1;
    localparam logic [HW-1:0] RUN_LAST = HW'(HOLDOFF - 1);

    pwm_cmd_t      raw;
    logic [HW-1:0] mid_run;

    assign raw = decode_pwm(pwm_above, pwm_below);

    // Mid-band must persist HOLDOFF samples before it is accepted (R7)
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd     <= CMD_MID;
            mid_run <= '0;
        end else if (raw == CMD_MID) begin
            if (mid_run == RUN_LAST) begin
                cmd <= CMD_MID;
            end else begin
                mid_run <= mid_run + 1'b1;
            end
        end else begin
            cmd     <= raw;
            mid_run <= '0;
        end
    end

endmodule

// File: rtl/bgs_sequencer.sv
module bgs_sequencer
    import bgs_pkg::*;
#(
    parameter int DT_TO_HS = 2,
    parameter int DT_TO_LS = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pwm_cmd_t cmd,
    input  logic     enable,
    input  logic     skip_n,
    input  logic     hs_fb_low,
    input  logic     ls_fb_low,
    input  logic     zero_cur,
    output logic     hs_en,
    output logic     ls_en
);
    localparam int DT_MAX = (DT_TO_HS > DT_TO_LS) ? DT_TO_HS : DT_TO_LS;
    localparam int DW     = $clog2(DT_MAX + 1);
    localparam logic [DW-1:0] HS_LAST = DW'(DT_TO_HS - 1);
    localparam logic [DW-1:0] LS_LAST = DW'(DT_TO_LS - 1);
    localparam logic [DW-1:0] CNT_TOP = DW'(DT_MAX);

    phase_t        ph, ph_nx;
    logic [DW-1:0] dwell, dwell_nx;
    logic          settled, dwell_ok, emulate;
    gate_pair_t    g_nx;

    assign emulate = ~skip_n;
    assign settled = hs_fb_low & ls_fb_low;

    always_comb begin
        if (cmd == CMD_HIGH) begin
            dwell_ok = (dwell >= HS_LAST);
        end else begin
            dwell_ok = (dwell >= LS_LAST);
        end
    end

    always_comb begin
        ph_nx = ph;
        unique case (ph)
            PH_OFF: begin
                if (cmd != CMD_MID && settled && dwell_ok) begin
                    if (cmd == CMD_HIGH) begin
                        ph_nx = PH_HS;
                    end else if (emulate && zero_cur) begin
                        ph_nx = PH_ZC;
                    end else begin
                        ph_nx = PH_LS;
                    end
                end
            end
            PH_HS: begin
                if (cmd != CMD_HIGH) ph_nx = PH_OFF;
            end
            PH_LS: begin
                if (cmd != CMD_LOW) begin
                    ph_nx = PH_OFF;
                end else if (emulate && zero_cur) begin
                    ph_nx = PH_ZC;
                end
            end
            PH_ZC: begin
                if (cmd != CMD_LOW) ph_nx = PH_OFF;
            end
        endcase
        if (!enable) ph_nx = PH_OFF;
    end

    always_comb begin
        if (enable && ph == PH_OFF && ph_nx == PH_OFF) begin
            dwell_nx = (dwell == CNT_TOP) ? dwell : dwell + 1'b1;
        end else begin
            dwell_nx = '0;
        end
    end

    assign g_nx = phase_gates(ph_nx);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_OFF;
            dwell <= '0;
            hs_en <= 1'b0;
            ls_en <= 1'b0;
        end else begin
            ph    <= ph_nx;
            dwell <= dwell_nx;
            hs_en <= g_nx.hs;
            ls_en <= g_nx.ls;
        end
    end

endmodule

// File: rtl/bgs_thermal.sv
module bgs_thermal #(
    parameter int TEMP_W     = 8,
    parameter int TEMP_TRIP  = 150,
    parameter int TEMP_CLEAR = 135
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              hot_n
);
    localparam logic [TEMP_W-1:0] TRIP_Q  = TEMP_W'(TEMP_TRIP);
    localparam logic [TEMP_W-1:0] CLEAR_Q = TEMP_W'(TEMP_CLEAR);

    logic hot;

    always_ff @(posedge clk) begin
        if (rst) begin
            hot <= 1'b0;
        end else if (temp_code >= TRIP_Q) begin
            hot <= 1'b1;
        end else if (temp_code <= CLEAR_Q) begin
            hot <= 1'b0;
        end
    end

    assign hot_n = ~hot;

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
    import bgs_pkg::*;
#(
    parameter int TEMP_W     = 8,
    parameter int TEMP_TRIP  = 150,
    parameter int TEMP_CLEAR = 135,
    parameter int HOLDOFF    = 17,
    parameter int DT_TO_HS   = 2,
    parameter int DT_TO_LS   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_above,
    input  logic              pwm_below,
    input  logic              dis_n,
    input  logic              skip_n,
    input  logic              supply_ok,
    input  logic              hs_fb_low,
    input  logic              ls_fb_low,
    input  logic              zero_cur,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              hs_en,
    output logic              ls_en,
    output logic              hot_n
);
    pwm_cmd_t cmd;
    logic     enable;

    assign enable = dis_n & supply_ok;

    bgs_pwm_filter #(.HOLDOFF(HOLDOFF)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .pwm_above (pwm_above),
        .pwm_below (pwm_below),
        .cmd       (cmd)
    );

    bgs_sequencer #(.DT_TO_HS(DT_TO_HS), .DT_TO_LS(DT_TO_LS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .enable    (enable),
        .skip_n    (skip_n),
        .hs_fb_low (hs_fb_low),
        .ls_fb_low (ls_fb_low),
        .zero_cur  (zero_cur),
        .hs_en     (hs_en),
        .ls_en     (ls_en)
    );

    bgs_thermal #(.TEMP_W(TEMP_W), .TEMP_TRIP(TEMP_TRIP), .TEMP_CLEAR(TEMP_CLEAR)) u_therm (
        .clk       (clk),
        .rst       (rst),
        .temp_code (temp_code),
        .hot_n     (hot_n)
    );

endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
    parameter int TEMP_W     = 8,
    parameter int TEMP_TRIP  = 150,
    parameter int TEMP_CLEAR = 135
) (
    input logic              clk,
    input logic              rst,
    input logic              dis_n,
    input logic              supply_ok,
    input logic              skip_n,
    input logic              zero_cur,
    input logic              hs_fb_low,
    input logic              ls_fb_low,
    input logic [TEMP_W-1:0] temp_code,
    input logic              hs_en,
    input logic              ls_en,
    input logic              hot_n
);
    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> (!hs_en && !ls_en && hot_n));

    assert_disable_off_R2: assert property (@(posedge clk) disable iff (rst)
        !dis_n |=> (!hs_en && !ls_en));

    assert_undervolt_off_R3: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (!hs_en && !ls_en));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));

    assert_hs_gap_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> $past(!ls_en));

    assert_ls_gap_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en) |-> $past(!hs_en));

    assert_hs_after_fb_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> $past(hs_fb_low && ls_fb_low));

    assert_ls_after_fb_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en) |-> $past(hs_fb_low && ls_fb_low));

    assert_zero_cur_off_R8: assert property (@(posedge clk) disable iff (rst)
        (ls_en && !skip_n && zero_cur) |=> !ls_en);

    assert_hot_set_R10: assert property (@(posedge clk) disable iff (rst)
        (temp_code >= TEMP_W'(TEMP_TRIP)) |=> !hot_n);

    assert_hot_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (temp_code <= TEMP_W'(TEMP_CLEAR)) |=> hot_n);

endmodule

bind buck_gate_seq bgs_checker #(
    .TEMP_W     (TEMP_W),
    .TEMP_TRIP  (TEMP_TRIP),
    .TEMP_CLEAR (TEMP_CLEAR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dis_n     (dis_n),
    .supply_ok (supply_ok),
    .skip_n    (skip_n),
    .zero_cur  (zero_cur),
    .hs_fb_low (hs_fb_low),
    .ls_fb_low (ls_fb_low),
    .temp_code (temp_code),
    .hs_en     (hs_en),
    .ls_en     (ls_en),
    .hot_n     (hot_n)
);

// File: tb/sim_buck_gate_seq.sv
module sim_buck_gate_seq;
    localparam int HOLDOFF  = 17;
    localparam int DT_TO_HS = 2;
    localparam int DT_TO_LS = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_above = 1'b0, pwm_below = 1'b0;
    logic       dis_n = 1'b1, skip_n = 1'b1, supply_ok = 1'b1;
    logic       hs_fb_low = 1'b1, ls_fb_low = 1'b1, zero_cur = 1'b0;
    logic [7:0] temp_code = 8'd25;
    logic       hs_en, ls_en, hot_n;

    int    checks = 0, errors = 0, cycles = 0;
    int    pd = 1;
    int    hs_off_run = 100, ls_off_run = 100;
    string tag = "R11";
    bit    live = 0;

    buck_gate_seq u0 (
        .clk(clk), .rst(rst), .pwm_above(pwm_above), .pwm_below(pwm_below),
        .dis_n(dis_n), .skip_n(skip_n), .supply_ok(supply_ok),
        .hs_fb_low(hs_fb_low), .ls_fb_low(ls_fb_low), .zero_cur(zero_cur),
        .temp_code(temp_code), .hs_en(hs_en), .ls_en(ls_en), .hot_n(hot_n)
    );

    always #5 clk = ~clk;

    // Plant: a gate reads as low pd cycles after its enable drops
    always @(negedge clk) begin
        if (hs_en === 1'b1) hs_off_run = 0; else hs_off_run++;
        if (ls_en === 1'b1) ls_off_run = 0; else ls_off_run++;
        hs_fb_low = (hs_off_run >= pd);
        ls_fb_low = (ls_off_run >= pd);
    end

    // Behavioural reference: cmd 0 mid, 1 high, 2 low; st 0 off, 1 hs, 2 ls, 3 parked
    int m_cmd = 0, m_run = 0, m_st = 0, m_dw = 0;
    bit m_hot = 0;
    always @(posedge clk) begin
        int raw, c, nst, need;
        bit en;
        if (rst) begin
            m_cmd = 0; m_run = 0; m_st = 0; m_dw = 0; m_hot = 0;
        end else begin
            c = m_cmd;
            if (pwm_above && !pwm_below) raw = 1;
            else if (!pwm_above && pwm_below) raw = 2;
            else raw = 0;
            if (raw == 0) begin
                if (m_run >= HOLDOFF - 1) m_cmd = 0;
                m_run++;
            end else begin
                m_cmd = raw;
                m_run = 0;
            end
            en = dis_n && supply_ok;
            nst = m_st;
            need = (c == 1) ? DT_TO_HS : DT_TO_LS;
            if (!en) nst = 0;
            else if (m_st == 0) begin
                if (c != 0 && hs_fb_low && ls_fb_low && m_dw + 1 >= need)
                    nst = (c == 1) ? 1 : ((!skip_n && zero_cur) ? 3 : 2);
            end else if (m_st == 1) begin
                if (c != 1) nst = 0;
            end else if (m_st == 2) begin
                if (c != 2) nst = 0;
                else if (!skip_n && zero_cur) nst = 3;
            end else begin
                if (c != 2) nst = 0;
            end
            m_dw = (en && m_st == 0 && nst == 0) ? ((m_dw < 1000) ? m_dw + 1 : m_dw) : 0;
            m_st = nst;
            if (temp_code >= 150) m_hot = 1;
            else if (temp_code <= 135) m_hot = 0;
        end
    end

    always @(negedge clk) begin
        if (live && !rst) begin
            checks++;
            if (hs_en !== (m_st == 1) || ls_en !== (m_st == 2) || hot_n !== !m_hot) begin
                errors++;
                $display("FAIL %s cycle %0d: hs/ls/hot_n=%b%b%b expected %b%b%b",
                         tag, cycles, hs_en, ls_en, hot_n, (m_st == 1), (m_st == 2), !m_hot);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pwm(input logic a, input logic b);
        pwm_above = a;
        pwm_below = b;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        cyc(4);
        chk("R11", hs_en, 1'b0, "hs_en in reset");
        chk("R11", ls_en, 1'b0, "ls_en in reset");
        chk("R11", hot_n, 1'b1, "hot_n in reset");
        rst = 1'b0;
        live = 1;
        cyc(3);
        chk("R11", hs_en | ls_en, 1'b0, "gates idle with mid command");

        // R6 complementary drive
        tag = "R6";
        for (int i = 0; i < 3; i++) begin
            pwm(1, 0); cyc(8);
            chk("R6", hs_en, 1'b1, "hs on for high");
            chk("R6", ls_en, 1'b0, "ls off for high");
            pwm(0, 1); cyc(8);
            chk("R6", ls_en, 1'b1, "ls on for low");
            chk("R6", hs_en, 1'b0, "hs off for low");
        end

        // R5 slow feedback stretches the dead time
        tag = "R5";
        pd = 6;
        pwm(1, 0); cyc(5);
        chk("R5", hs_en, 1'b0, "hs waits for feedback");
        cyc(6);
        chk("R5", hs_en, 1'b1, "hs on after feedback");
        pwm(0, 1); cyc(12);
        chk("R5", ls_en, 1'b1, "ls on after feedback");
        pd = 1;
        pwm(1, 0); cyc(8);

        // R7 hold-off filter
        tag = "R7";
        pwm(0, 0); cyc(HOLDOFF - 1);
        pwm(1, 0); cyc(4);
        chk("R7", hs_en, 1'b1, "short mid excursion ignored");
        pwm(0, 0); cyc(HOLDOFF + 3);
        chk("R7", hs_en | ls_en, 1'b0, "long mid turns gates off");
        tag = "R1";
        pwm(0, 1); cyc(8);
        chk("R1", ls_en, 1'b1, "low code drives low side");
        pwm(1, 1); cyc(HOLDOFF + 3);
        chk("R1", hs_en | ls_en, 1'b0, "illegal code acts as mid");

        // R2 disable
        tag = "R2";
        pwm(1, 0); cyc(8);
        dis_n = 1'b0; cyc(1);
        chk("R2", hs_en, 1'b0, "disable drops hs next cycle");
        pwm(0, 1); cyc(6);
        chk("R2", hs_en | ls_en, 1'b0, "gates held off while disabled");
        dis_n = 1'b1; cyc(6);
        chk("R2", ls_en, 1'b1, "resumes after enable");

        // R3 undervoltage
        tag = "R3";
        supply_ok = 1'b0; cyc(1);
        chk("R3", ls_en, 1'b0, "undervoltage drops ls");
        pwm(1, 0); cyc(6);
        chk("R3", hs_en | ls_en, 1'b0, "gates held off in undervoltage");
        supply_ok = 1'b1; cyc(1);
        chk("R3", hs_en, 1'b0, "no instant turn-on after recovery");
        cyc(6);
        chk("R3", hs_en, 1'b1, "hs on after recovery");

        // R8 diode emulation
        tag = "R8";
        skip_n = 1'b0;
        pwm(0, 1); cyc(8);
        chk("R8", ls_en, 1'b1, "ls on in emulation");
        zero_cur = 1'b1; cyc(1);
        chk("R8", ls_en, 1'b0, "ls off at zero current");
        zero_cur = 1'b0; cyc(6);
        chk("R8", ls_en, 1'b0, "ls stays off until next low edge");
        pwm(1, 0); cyc(8);
        chk("R8", hs_en, 1'b1, "hs follows pwm in emulation");
        pwm(0, 1); cyc(8);
        chk("R8", ls_en, 1'b1, "ls on again after new low edge");

        // R9 zero current ignored outside skip
        tag = "R9";
        skip_n = 1'b1;
        zero_cur = 1'b1; cyc(6);
        chk("R9", ls_en, 1'b1, "zero current ignored");
        zero_cur = 1'b0;

        // R10 thermal hysteresis
        tag = "R10";
        pwm(1, 0); cyc(8);
        temp_code = 8'd149; cyc(2);
        chk("R10", hot_n, 1'b1, "149 below trip");
        temp_code = 8'd150; cyc(1);
        chk("R10", hot_n, 1'b0, "trip at 150");
        chk("R10", hs_en, 1'b1, "flag does not gate hs");
        temp_code = 8'd136; cyc(3);
        chk("R10", hot_n, 1'b0, "held at 136");
        temp_code = 8'd135; cyc(1);
        chk("R10", hot_n, 1'b1, "clear at 135");
        temp_code = 8'd200; cyc(2);
        chk("R10", hot_n, 1'b0, "trip at 200");
        temp_code = 8'd60; cyc(2);

        // Pseudo-random codes and modes, compared against the reference every cycle
        tag = "R1";
        lfsr = 8'hA5;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            pwm(lfsr[0], lfsr[1]);
            skip_n = lfsr[4] | lfsr[6];
            zero_cur = lfsr[2] & lfsr[5];
            pd = lfsr[7] ? 3 : 1;
            cyc(1 + lfsr[3] * 4);
        end
        pd = 1;
        cyc(5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule